// File: doc/BRIEF.md
# Command Queue Register Interface

This block holds the three software-visible control registers of a command queue that lives in memory: the queue base, the producer (write) pointer and the consumer (read) pointer. Software reaches each 64-bit register through a simple request/response bus. It can use one 64-bit access or two independent 32-bit accesses, one to the low word at the register offset and one to the high word at offset plus 4. Every request gets a registered response one cycle later, carrying read data or an error flag.

Whenever software updates the base or the write pointer, the block emits a one-cycle check pulse. On that pulse it re-evaluates whether commands are outstanding. Updating the base, through either half, also rewinds the read pointer to zero. A downstream command fetcher consumes commands through a consume/acknowledge port. Each accepted consume moves the read pointer forward by one 32-byte command and wraps it at the queue size programmed in the base register. The block does not fetch or execute commands. It only stores the cacheability attributes.

Register map (byte offsets): base at 0x00, write pointer at 0x08, read pointer at 0x10. The read pointer can only be read.

Top module: `cmdq_regs`

## Requirements
- R1: After a synchronous active-low reset, all three registers read as zero, `cmd_pending`, `chk_pulse`, `rsp_valid` and `rsp_err` are 0, and `consume_ack` is 0.
- R2: A 64-bit write (`bus_wide`=1) at the low offset of base or write pointer replaces all 64 bits. A 64-bit read there returns all 64 bits in `rsp_rdata`.
- R3: A 32-bit write at the low offset takes `bus_wdata[31:0]` into register bits [31:0] and leaves bits [63:32] unchanged. A 32-bit read there returns bits [31:0] in `rsp_rdata[31:0]`, with `rsp_rdata[63:32]` zero.
- R4: A 32-bit write at offset plus 4 takes `bus_wdata[31:0]` into register bits [63:32] and leaves bits [31:0] unchanged. A 32-bit read there returns bits [63:32] in `rsp_rdata[31:0]`, with the upper word zero.
- R5: Any accepted write to either half of the base register clears the read-pointer offset to zero at the same clock edge.
- R6: An accepted write to base or write pointer raises `chk_pulse` for exactly the response cycle. Reads and rejected requests never raise it.
- R7: In the cycle after a check pulse, `cmd_pending` equals base bit 63 (valid) AND (write-pointer bits [19:5] differ from read-pointer bits [19:5]). Outside check pulses and consumes it holds its value.
- R8: When `consume` is high and `consume_ack` is high, the read-pointer offset (bits [19:5]) advances by one. It wraps to zero when it reaches (base[7:0]+1)*128 entries. `cmd_pending` then becomes (new offset differs from write-pointer offset). `consume_ack` is 0 when nothing is pending, and the offset then does not change.
- R9: A request is rejected with `rsp_err`=1, zero read data and no register change when any of these holds: address bits [1:0] are nonzero; the address is 0x18 or above; it is a 64-bit access at offset plus 4; it is a write to the read pointer.
- R10: A consume in a cycle with an accepted register write, or in a check-pulse cycle, is not acknowledged. The read pointer is left unchanged, so the software write wins.
- R11: The read pointer reads back with its offset in bits [19:5] and all other bits zero. The same value appears on `rptr_o`. `base_o` and `wptr_o` show the stored registers.
- R12: Every request accepted while `bus_valid` is high produces `rsp_valid`=1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 64 | Write data; 32-bit accesses use bits [31:0] |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Request was rejected |
| rsp_rdata | output | 64 | Read data, zero for writes and errors |
| chk_pulse | output | 1 | One-cycle queue re-check request |
| cmd_pending | output | 1 | Commands outstanding between read and write pointers |
| consume | input | 1 | Consumer requests to retire one command |
| consume_ack | output | 1 | Consume accepted this cycle |
| base_o | output | 64 | Current base register |
| wptr_o | output | 64 | Current write-pointer register |
| rptr_o | output | 64 | Current read-pointer value |

## Verification
The hardest state to reach from the ports is the wrap of the read pointer. It needs a valid base, a write-pointer offset that lies behind the current read offset, and more than a hundred acknowledged consumes without the pending flag dropping early. The bench gets there by first draining the queue to a known offset. It then reprograms the write pointer below that offset and consumes through the whole ring, for the smallest queue size and again for the next size up. A consume placed in the check-pulse cycle and a consume that coincides with a bus write cover the write-over-consume priority. A sweep over every address and width, for reads and writes, covers the decode and error rules against an arithmetic model.

// File: rtl/cmdq_pkg.sv
// Package: shared field positions, register offsets and decode types for the
// command queue register block. Assumes 64-bit registers split in 32-bit halves.
package cmdq_pkg;
    localparam int REG_W     = 64;
    localparam int HALF_W    = REG_W / 2;
    localparam int OFF_LSB   = 5;
    localparam int OFF_MSB   = 19;
    localparam int OFF_W     = OFF_MSB - OFF_LSB + 1;
    localparam int SIZE_W    = 8;
    localparam int VALID_BIT = 63;
    localparam int PAGE_LOG2 = 12;
    localparam int CMD_LOG2  = 5;

    localparam int OFS_BASE  = 'h00;
    localparam int OFS_WPTR  = 'h08;
    localparam int OFS_RPTR  = 'h10;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_BASE = 2'd1,
        SEL_WPTR = 2'd2,
        SEL_RPTR = 2'd3
    } sel_e;

    typedef struct packed {
        sel_e sel;
        logic hi;
        logic err;
    } dec_t;

    // Combine write data into a register according to access width and half.
    function automatic logic [REG_W-1:0] merge_half(
        input logic [REG_W-1:0] cur,
        input logic [REG_W-1:0] wd,
        input logic             wide,
        input logic             hi
    );
        if (wide) begin
            return wd;
        end else if (hi) begin
            return {wd[HALF_W-1:0], cur[HALF_W-1:0]};
        end else begin
            return {cur[REG_W-1:HALF_W], wd[HALF_W-1:0]};
        end
    endfunction
endpackage

// File: rtl/cmdq_decode.sv
// Module: address decoder for the register block.
// Maps a byte offset, width and direction to a register select, a half flag
// and an error flag. Assumes ADDR_W >= 5 so that all three registers fit.
module cmdq_decode
    import cmdq_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide,
    input  logic              write,
    output dec_t              dec
);
    logic [ADDR_W-1:0] word_addr;
    logic              misaligned;
    sel_e              sel;

    // Word base address of the 64-bit register that the access falls in.
    assign word_addr  = {addr[ADDR_W-1:3], 3'b000};
    assign misaligned = (addr[1:0] != 2'b00);

    // Pick the register addressed by the word base.
    always_comb begin
        if (word_addr == ADDR_W'(OFS_BASE)) begin
            sel = SEL_BASE;
        end else if (word_addr == ADDR_W'(OFS_WPTR)) begin
            sel = SEL_WPTR;
        end else if (word_addr == ADDR_W'(OFS_RPTR)) begin
            sel = SEL_RPTR;
        end else begin
            sel = SEL_NONE;
        end
    end

    // Gather select, half and the rejection conditions.
    always_comb begin
        dec.sel = sel;
        dec.hi  = addr[2];
        dec.err = misaligned
                | (sel == SEL_NONE)
                | (wide & addr[2])
                | (write & (sel == SEL_RPTR));
    end
endmodule

// File: rtl/cmdq_rdptr.sv
// Module: read-pointer offset register for the command queue.
// Advances one command per acknowledged consume, wraps at the queue size taken
// from the base size field, and rewinds to zero on clear. Assumes clear only
// occurs together with block (a software write is under way).
module cmdq_rdptr
    import cmdq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              block,
    input  logic [SIZE_W-1:0] size,
    input  logic              consume,
    input  logic              pending,
    output logic              ack,
    output logic [OFF_W-1:0]  roff,
    output logic [OFF_W-1:0]  roff_adv
);
    localparam int SHIFT = PAGE_LOG2 - CMD_LOG2;

    logic [OFF_W-1:0]  roff_q;
    logic [SIZE_W:0]   pages;
    logic [OFF_W:0]    limit;
    logic [OFF_W:0]    inc;

    // Queue length in commands: (size + 1) pages of 2^SHIFT commands.
    assign pages = {1'b0, size} + {{SIZE_W{1'b0}}, 1'b1};
    assign limit = {{(OFF_W - SIZE_W){1'b0}}, pages} << SHIFT;

    // Candidate next offset with wrap at the queue length.
    assign inc      = {1'b0, roff_q} + {{OFF_W{1'b0}}, 1'b1};
    assign roff_adv = (inc >= limit) ? '0 : inc[OFF_W-1:0];

    // A consume is taken only when work is pending and software is not writing.
    assign ack = consume & pending & ~block;

    // Offset register: clear wins over advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            roff_q <= '0;
        end else if (clear) begin
            roff_q <= '0;
        end else if (ack) begin
            roff_q <= roff_adv;
        end
    end

    assign roff = roff_q;

    assert_clear_rewinds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (roff_q == '0));

    assert_offset_in_ring_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, roff_q} < limit));

    assert_write_beats_consume_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && block && !clear) |=> (roff_q == $past(roff_q)));
endmodule

// File: rtl/cmdq_pending.sv
// Module: pending-work flag for the command queue.
// Re-evaluated on each check pulse from the valid bit and both offsets, and
// after each acknowledged consume from the advanced offset. Assumes ack is
// never high in a check-pulse cycle.
module cmdq_pending
    import cmdq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk,
    input  logic             base_valid,
    input  logic [OFF_W-1:0] woff,
    input  logic [OFF_W-1:0] roff,
    input  logic             ack,
    input  logic [OFF_W-1:0] roff_adv,
    output logic             pending
);
    logic pend_q;

    // Update the flag on a check or after a retired command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (chk) begin
            pend_q <= base_valid & (woff != roff);
        end else if (ack) begin
            pend_q <= (roff_adv != woff);
        end
    end

    assign pending = pend_q;

    assert_rise_only_on_check_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(chk));

    assert_drain_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && (roff_adv == woff)) |=> !pend_q);
endmodule

// File: rtl/cmdq_regs.sv
// Module: command queue register interface (top).
// Holds base and write-pointer registers with split 32-bit or whole 64-bit
// access, returns registered read responses, emits a check pulse on software
// updates and hosts the read pointer and pending flag. Assumes one request per
// cycle with no back-pressure.
module cmdq_regs
    import cmdq_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_wide,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [REG_W-1:0]  rsp_rdata,
    output logic              chk_pulse,
    output logic              cmd_pending,
    input  logic              consume,
    output logic              consume_ack,
    output logic [REG_W-1:0]  base_o,
    output logic [REG_W-1:0]  wptr_o,
    output logic [REG_W-1:0]  rptr_o
);
    dec_t             dec;
    logic [REG_W-1:0] base_q;
    logic [REG_W-1:0] wptr_q;
    logic [REG_W-1:0] rptr_val;
    logic [REG_W-1:0] sel_val;
    logic [REG_W-1:0] rd_val;
    logic [OFF_W-1:0] roff;
    logic [OFF_W-1:0] roff_adv;
    logic             accept;
    logic             sw_wr;
    logic             base_we;
    logic             wptr_we;
    logic             rsp_valid_q;
    logic             rsp_err_q;
    logic [REG_W-1:0] rsp_rdata_q;
    logic             chk_q;

    cmdq_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr  (bus_addr),
        .wide  (bus_wide),
        .write (bus_write),
        .dec   (dec)
    );

    // Write strobes for accepted software writes.
    assign accept  = bus_valid & ~dec.err;
    assign sw_wr   = accept & bus_write;
    assign base_we = sw_wr & (dec.sel == SEL_BASE);
    assign wptr_we = sw_wr & (dec.sel == SEL_WPTR);

    // Base register storage with half-word merge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (base_we) begin
            base_q <= merge_half(base_q, bus_wdata, bus_wide, dec.hi);
        end
    end

    // Write-pointer register storage with half-word merge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
        end else if (wptr_we) begin
            wptr_q <= merge_half(wptr_q, bus_wdata, bus_wide, dec.hi);
        end
    end

    cmdq_rdptr u_rdptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (base_we),
        .block    (sw_wr | chk_q),
        .size     (base_q[SIZE_W-1:0]),
        .consume  (consume),
        .pending  (cmd_pending),
        .ack      (consume_ack),
        .roff     (roff),
        .roff_adv (roff_adv)
    );

    cmdq_pending u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .chk        (chk_q),
        .base_valid (base_q[VALID_BIT]),
        .woff       (wptr_q[OFF_MSB:OFF_LSB]),
        .roff       (roff),
        .ack        (consume_ack),
        .roff_adv   (roff_adv),
        .pending    (cmd_pending)
    );

    // Read pointer as seen by software: offset field only, other bits zero.
    assign rptr_val = {{(REG_W - OFF_MSB - 1){1'b0}}, roff, {OFF_LSB{1'b0}}};

    // Select the addressed register for readback.
    always_comb begin
        case (dec.sel)
            SEL_BASE: sel_val = base_q;
            SEL_WPTR: sel_val = wptr_q;
            SEL_RPTR: sel_val = rptr_val;
            default:  sel_val = '0;
        endcase
    end

    // Shape read data by access width and half.
    always_comb begin
        if (bus_wide) begin
            rd_val = sel_val;
        end else if (dec.hi) begin
            rd_val = {{HALF_W{1'b0}}, sel_val[REG_W-1:HALF_W]};
        end else begin
            rd_val = {{HALF_W{1'b0}}, sel_val[HALF_W-1:0]};
        end
    end

    // Registered response and check pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            rsp_rdata_q <= '0;
            chk_q       <= 1'b0;
        end else begin
            rsp_valid_q <= bus_valid;
            rsp_err_q   <= bus_valid & dec.err;
            rsp_rdata_q <= (accept & ~bus_write) ? rd_val : '0;
            chk_q       <= base_we | wptr_we;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_err   = rsp_err_q;
    assign rsp_rdata = rsp_rdata_q;
    assign chk_pulse = chk_q;
    assign base_o    = base_q;
    assign wptr_o    = wptr_q;
    assign rptr_o    = rptr_val;

    assert_pulse_from_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chk_q |-> ($past(bus_valid && bus_write) && rsp_valid_q && !rsp_err_q));

    assert_reject_keeps_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err_q |-> ($stable(base_q) && $stable(wptr_q) && (rsp_rdata_q == '0)));

    assert_response_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> rsp_valid_q);
endmodule

// File: tb/sim_cmdq_regs.sv
// Bench: near-exhaustive sweep of address/width/direction against an
// arithmetic model, plus directed consume, wrap and priority sequences.
module sim_cmdq_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic        bus_wide = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic        rsp_valid, rsp_err, chk_pulse, cmd_pending, consume_ack;
    logic [63:0] rsp_rdata, base_o, wptr_o, rptr_o;
    logic        consume = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [63:0] m_base = '0;
    logic [63:0] m_wptr = '0;
    logic [14:0] m_roff = '0;
    bit          m_pend = 1'b0;

    always #2 clk = ~clk;

    cmdq_regs #(.ADDR_W(5)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .chk_pulse(chk_pulse), .cmd_pending(cmd_pending), .consume(consume),
        .consume_ack(consume_ack), .base_o(base_o), .wptr_o(wptr_o), .rptr_o(rptr_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic bit e_err(bit wr, bit wd, logic [4:0] a);
        return (a[1:0] != 2'b00) || (a >= 5'h18) || (wd && a[2]) || (wr && a[4:3] == 2'd2);
    endfunction

    function automatic logic [63:0] e_rptr();
        return {44'd0, m_roff, 5'd0};
    endfunction

    function automatic logic [63:0] e_read(bit wd, logic [4:0] a);
        logic [63:0] v;
        v = (a[4:3] == 2'd0) ? m_base : (a[4:3] == 2'd1) ? m_wptr : e_rptr();
        if (wd) return v;
        return a[2] ? {32'd0, v[63:32]} : {32'd0, v[31:0]};
    endfunction

    function automatic logic [63:0] e_merge(logic [63:0] cur, logic [63:0] d, bit wd, bit hi);
        if (wd) return d;
        if (hi) return {d[31:0], cur[31:0]};
        return {cur[63:32], d[31:0]};
    endfunction

    // Model a write; returns whether a check pulse is expected.
    function automatic bit m_write(bit wd, logic [4:0] a, logic [63:0] d);
        if (e_err(1'b1, wd, a)) return 1'b0;
        if (a[4:3] == 2'd0) begin
            m_base = e_merge(m_base, d, wd, a[2]);
            m_roff = '0;
        end else begin
            m_wptr = e_merge(m_wptr, d, wd, a[2]);
        end
        m_pend = m_base[63] && (m_wptr[19:5] != m_roff);
        return 1'b1;
    endfunction

    task automatic bus_op(input bit wr, input bit wd, input logic [4:0] a,
                          input logic [63:0] d, output logic [63:0] rd,
                          output bit er, output bit pu);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_wide = wd; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        rd = rsp_rdata; er = rsp_err; pu = chk_pulse;
        chk("R12 rsp_valid", {63'd0, rsp_valid}, 64'd1);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic wr_chk(input string tag, input bit wd, input logic [4:0] a, input logic [63:0] d);
        logic [63:0] rd; bit er, pu, epu;
        epu = m_write(wd, a, d);
        bus_op(1'b1, wd, a, d, rd, er, pu);
        chk({tag, " err"}, {63'd0, er}, {63'd0, e_err(1'b1, wd, a)});
        chk("R6 pulse", {63'd0, pu}, {63'd0, epu});
    endtask

    task automatic rd_chk(input string tag, input bit wd, input logic [4:0] a);
        logic [63:0] rd; bit er, pu;
        bus_op(1'b0, wd, a, 64'd0, rd, er, pu);
        chk({tag, " err"}, {63'd0, er}, {63'd0, e_err(1'b0, wd, a)});
        chk({tag, " rdata"}, rd, e_err(1'b0, wd, a) ? 64'd0 : e_read(wd, a));
        chk("R6 no pulse on read", {63'd0, pu}, 64'd0);
    endtask

    task automatic do_consume(input string tag);
        int lim; logic [14:0] nxt;
        @(negedge clk);
        consume = 1'b1; #1;
        chk({tag, " ack"}, {63'd0, consume_ack}, {63'd0, m_pend});
        @(posedge clk); #1;
        consume = 1'b0;
        if (m_pend) begin
            lim = (int'(m_base[7:0]) + 1) * 128;
            nxt = m_roff + 15'd1;
            if (int'(nxt) >= lim) nxt = '0;
            m_roff = nxt;
            m_pend = (nxt != m_wptr[19:5]);
        end
        chk({tag, " rptr_o"}, rptr_o, e_rptr());
        chk({tag, " pending"}, {63'd0, cmd_pending}, {63'd0, m_pend});
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] rd; bit er, pu;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
        chk("R1 pulse", {63'd0, chk_pulse}, 64'd0);
        chk("R1 pending", {63'd0, cmd_pending}, 64'd0);
        chk("R1 base", base_o, 64'd0);
        chk("R1 wptr", wptr_o, 64'd0);
        chk("R1 rptr", rptr_o, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        rd_chk("R1 read base", 1'b1, 5'h00);
        rd_chk("R1 read wptr", 1'b1, 5'h08);

        // Whole-register and half-register writes.
        wr_chk("R2 wide base", 1'b1, 5'h00, 64'h0123_4567_89AB_CD00);
        rd_chk("R2 wide read", 1'b1, 5'h00);
        wr_chk("R3 low base", 1'b0, 5'h00, 64'hFFFF_FFFF_DEAD_BE01);
        chk("R3 base after low", base_o, 64'h0123_4567_DEAD_BE01);
        rd_chk("R3 low read", 1'b0, 5'h00);
        wr_chk("R4 high base", 1'b0, 5'h04, 64'h5555_5555_8000_0000);
        chk("R4 base after high", base_o, 64'h8000_0000_DEAD_BE01);
        rd_chk("R4 high read", 1'b0, 5'h04);
        wr_chk("R2 wide wptr", 1'b1, 5'h08, 64'hCAFE_0000_0003_1AE1);
        chk("R11 wptr_o", wptr_o, 64'hCAFE_0000_0003_1AE1);

        // Read sweep over every offset and width.
        for (int a = 0; a < 32; a++) begin
            for (int w = 0; w < 2; w++) begin
                rd_chk("R9 read sweep", w[0], a[4:0]);
            end
        end

        // Write sweep over every offset and width, with readback of all registers.
        for (int a = 0; a < 32; a++) begin
            for (int w = 0; w < 2; w++) begin
                logic [63:0] d;
                d = {32'h9E37_79B9 ^ (a * 32'h0101_0101), 32'h7F4A_7C15 + a * 32'h0000_1025 + w};
                wr_chk("R9 write sweep", w[0], a[4:0], d);
                rd_chk("R2 sweep base", 1'b1, 5'h00);
                rd_chk("R2 sweep wptr", 1'b1, 5'h08);
                rd_chk("R11 sweep rptr", 1'b1, 5'h10);
                chk("R7 sweep pending", {63'd0, cmd_pending}, {63'd0, m_pend});
            end
        end

        // Smallest queue, valid, write offset 5.
        wr_chk("R5 base setup", 1'b1, 5'h00, 64'h8000_0000_0000_0000);
        wr_chk("R7 wptr setup", 1'b1, 5'h08, 64'h0000_0000_0000_00A1);
        @(negedge clk);
        chk("R7 pending set", {63'd0, cmd_pending}, 64'd1);
        for (int i = 0; i < 5; i++) do_consume("R8 drain");
        chk("R8 drained", {63'd0, cmd_pending}, 64'd0);
        do_consume("R8 idle consume");
        rd_chk("R11 rptr read", 1'b1, 5'h10);
        rd_chk("R11 rptr high", 1'b0, 5'h14);

        // Write offset 3, behind the read offset; consume in the pulse cycle.
        m_write(1'b1, 5'h08, 64'h60);
        bus_op(1'b1, 1'b1, 5'h08, 64'h60, rd, er, pu);
        consume = 1'b1; #1;
        chk("R10 ack in pulse cycle", {63'd0, consume_ack}, 64'd0);
        @(posedge clk); #1;
        consume = 1'b0;
        chk("R10 rptr held in pulse", rptr_o, e_rptr());
        chk("R7 pending after recheck", {63'd0, cmd_pending}, 64'd1);

        // Consume together with a bus write.
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_wide = 1'b1; bus_addr = 5'h08; bus_wdata = 64'h60;
        consume = 1'b1; #1;
        chk("R10 ack with write", {63'd0, consume_ack}, 64'd0);
        @(posedge clk); #1;
        consume = 1'b0;
        chk("R10 rptr held with write", rptr_o, e_rptr());
        void'(m_write(1'b1, 5'h08, 64'h60));
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;

        // Ring wrap at 128 entries.
        for (int i = 0; i < 122; i++) do_consume("R8 ring");
        chk("R8 at last entry", rptr_o, 64'd127 << 5);
        do_consume("R8 wrap");
        chk("R8 wrapped to zero", rptr_o, 64'd0);
        for (int i = 0; i < 3; i++) do_consume("R8 catch up");
        chk("R8 caught up", {63'd0, cmd_pending}, 64'd0);

        // Base high-half write rewinds the read pointer.
        wr_chk("R5 base high write", 1'b0, 5'h04, 64'h8000_0000);
        chk("R5 rptr cleared", rptr_o, 64'd0);
        @(negedge clk);
        chk("R7 pending after rewind", {63'd0, cmd_pending}, 64'd1);
        wr_chk("R7 base invalid", 1'b1, 5'h00, 64'd0);
        @(negedge clk);
        chk("R7 invalid gives no pending", {63'd0, cmd_pending}, 64'd0);

        // Two-page queue wraps at 256 entries.
        wr_chk("R8 size one", 1'b1, 5'h00, 64'h8000_0000_0000_0001);
        wr_chk("R8 far wptr", 1'b1, 5'h08, 64'h0000_0000_000F_FFE0);
        for (int i = 0; i < 255; i++) do_consume("R8 big ring");
        chk("R8 at entry 255", rptr_o, 64'd255 << 5);
        do_consume("R8 big wrap");
        chk("R8 big wrapped", rptr_o, 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule